// File: doc/BRIEF.md
# LPC Memory Cycle Target

This block is the target side of single-byte LPC memory read and memory write cycles. On every clock it samples the 4-bit multiplexed LAD bus and the active-low frame strobe. It recognises the start nibble, decodes whether the cycle is a memory read or a memory write, and assembles the 32-bit address. It then compares that address against a host-accessible window, which is set by a base value, a don't-care mask and an enable.

When the address falls inside the window, the block takes the cycle. It lets the host turn the bus around, inserts long-wait sync nibbles for as long as its local byte memory takes, and signals ready exactly once. It then moves one byte over LAD and hands the bus back. When the address misses, or the cycle type is anything else, the block stays off the bus and waits for the next frame.

The local side is a request/done pair. The address, the write flag and the write byte are held stable while the request is high. The read byte is captured on the done pulse.

Top module: `lpc_mem_target`

## Requirements
- R1: While reset is high and on the first clock after it, `lad_oe` and `mem_req` are 0.
- R2: A clock with `frame_n` low always returns the sequencer to start detection. It starts a new cycle only if LAD is 0000 on that clock. On the next clock `lad_oe` and `mem_req` are 0. This holds even when a local completion is sampled on the same edge; in that case no ready sync follows.
- R3: The nibble after the start selects the cycle: 0100 is a memory read and 0110 is a memory write. Any other value ends the cycle, with no bus drive and no local request.
- R4: The address arrives as eight nibbles, bits 31..28 first and bits 3..0 last. `mem_addr` carries the full address while `mem_req` is high.
- R5: A cycle is claimed only when `win_en` is 1 and the address equals `win_base` at every bit where `win_mask` is 0. Bits where the mask is 1 are ignored in both the address and the base. A missed cycle never drives LAD, never raises `mem_req`, and leaves memory contents unchanged.
- R6: In a write, the two nibbles that follow the address are the data byte, bits 3..0 first. They appear on `mem_wdata`.
- R7: The target does not drive LAD during any host clock. It also does not drive during the two turnaround clocks after the last host nibble. `mem_req` rises at the first of these turnaround clocks.
- R8: From the third clock after the request rises, the target drives a sync nibble each clock. The nibble is 0110 (long wait) until a done has been sampled, then 0000 (ready) exactly once. 1010 is never driven as a sync. With a local latency of d clocks, the bench expects max(0, d-1) long waits.
- R9: In a read, after ready the target drives the read byte, bits 3..0 first. It then drives 1111 for one clock and releases LAD on the next clock.
- R10: In a write, after ready the target drives 1111 for one clock and releases LAD on the next clock.
- R11: `mem_req` stays high until `mem_done` is sampled and drops on the following clock. `mem_we` is 1 for writes and 0 for reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low cycle framing strobe |
| lad_in | input | 4 | Sampled LAD nibble |
| lad_out | output | 4 | Nibble driven onto LAD |
| lad_oe | output | 1 | LAD output enable |
| win_base | input | 32 | Window base address |
| win_mask | input | 32 | Window don't-care bits (1 = ignored) |
| win_en | input | 1 | Window decode enable |
| mem_req | output | 1 | Local access request, level held until done |
| mem_we | output | 1 | Local access is a write |
| mem_addr | output | 32 | Local access address |
| mem_wdata | output | 8 | Local write byte |
| mem_rdata | input | 8 | Local read byte, valid with done |
| mem_done | input | 1 | Local access complete (one-clock pulse) |

## Verification
Two events can land on the same clock edge: completion of the local access, and a frame-strobe abort. Completion decides whether the next sync nibble is ready or long-wait, and an abort must win over it. The bench times a read with a one-clock local latency so that `mem_done` and a low `frame_n` are sampled on the same edge. It then requires the bus to be released and the request dropped, with no ready nibble.

The bench also sweeps local latency from zero upward. At the short end, completion overlaps the turnaround clocks, and the count of long-wait nibbles must match max(0, d-1) for every latency.

// File: rtl/lpcm_pkg.sv
package lpcm_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    localparam logic [NIB_W-1:0] NIB_START  = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_MEM_RD = 4'b0100;
    localparam logic [NIB_W-1:0] NIB_MEM_WR = 4'b0110;
    localparam logic [NIB_W-1:0] NIB_TAR    = 4'b1111;
    localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_LWAIT = 4'b0110;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTYPE,
        S_ADDR,
        S_WLO,
        S_WHI,
        S_HTAR1,
        S_HTAR2,
        S_SYNC,
        S_RLO,
        S_RHI,
        S_PTAR
    } lpcm_state_e;

    typedef struct packed {
        logic             oe;
        logic [NIB_W-1:0] nib;
    } lad_drive_t;

    // States in which only the host may own LAD
    function automatic logic is_host_phase(lpcm_state_e s);
        return (s == S_CTYPE) || (s == S_ADDR) || (s == S_WLO) ||
               (s == S_WHI)   || (s == S_HTAR1) || (s == S_HTAR2);
    endfunction

    function automatic logic [NIB_W-1:0] sync_code(logic access_done);
        return access_done ? SYNC_READY : SYNC_LWAIT;
    endfunction

endpackage

// File: rtl/lpcm_window.sv
module lpcm_window
    import lpcm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic              en,
    output logic              hit
);

    localparam int NIBS = ADDR_W / NIB_W;

    logic [NIBS-1:0] nib_ok;

    // One compare slice per address nibble; masked bits never mismatch
    for (genvar g = 0; g < NIBS; g++) begin : g_slice
        assign nib_ok[g] =
            (((addr[g*NIB_W +: NIB_W] ^ base[g*NIB_W +: NIB_W]) &
              ~mask[g*NIB_W +: NIB_W]) == '0);
    end

    assign hit = en & (&nib_ok);

endmodule

// File: rtl/lpcm_collect.sv
module lpcm_collect
    import lpcm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  lad_in,
    input  logic              addr_shift,
    input  logic              data_lo,
    input  logic              data_hi,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_next,
    output logic [BYTE_W-1:0] data_q
);

    // Address enters most significant nibble first
    assign addr_next = {addr_q[ADDR_W-NIB_W-1:0], lad_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (addr_shift) begin
                addr_q <= addr_next;
            end
            if (data_lo) begin
                data_q[NIB_W-1:0] <= lad_in;
            end
            if (data_hi) begin
                data_q[BYTE_W-1:NIB_W] <= lad_in;
            end
        end
    end

endmodule

// File: rtl/lpcm_seq.sv
module lpcm_seq
    import lpcm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  lad_in,
    input  logic              win_hit,
    input  logic              mem_done,
    input  logic [BYTE_W-1:0] mem_rdata,
    output lpcm_state_e       state,
    output logic              addr_shift,
    output logic              data_lo,
    output logic              data_hi,
    output logic              mem_req,
    output logic              mem_we,
    output logic [NIB_W-1:0]  lad_out,
    output logic              lad_oe
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int CNT_W     = $clog2(ADDR_NIBS);
    localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(ADDR_NIBS - 1);

    lpcm_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q;
    logic              req_q;
    logic              done_q;
    logic [BYTE_W-1:0] rd_q;
    lad_drive_t        drv;

    logic abort;
    logic accept;
    logic req_start;

    assign abort     = ~frame_n;
    assign accept    = req_q & mem_done;
    assign req_start = (state_d == S_HTAR1) && (state_q != S_HTAR1);

    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = (lad_in == NIB_START) ? S_CTYPE : S_IDLE;
        end else begin
            case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_CTYPE: begin
                    if ((lad_in == NIB_MEM_RD) || (lad_in == NIB_MEM_WR)) begin
                        state_d = S_ADDR;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
                S_ADDR: begin
                    if (cnt_q == LAST_NIB) begin
                        if (!win_hit)  state_d = S_IDLE;
                        else if (wr_q) state_d = S_WLO;
                        else           state_d = S_HTAR1;
                    end
                end
                S_WLO:   state_d = S_WHI;
                S_WHI:   state_d = S_HTAR1;
                S_HTAR1: state_d = S_HTAR2;
                S_HTAR2: state_d = S_SYNC;
                S_SYNC: begin
                    if (done_q) state_d = wr_q ? S_PTAR : S_RLO;
                end
                S_RLO:   state_d = S_RHI;
                S_RHI:   state_d = S_PTAR;
                S_PTAR:  state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    assign addr_shift = frame_n && (state_q == S_ADDR);
    assign data_lo    = frame_n && (state_q == S_WLO);
    assign data_hi    = frame_n && (state_q == S_WHI);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            req_q   <= 1'b0;
            done_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;

            if (state_q == S_CTYPE) begin
                cnt_q <= '0;
            end else if (addr_shift) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (frame_n && (state_q == S_CTYPE)) begin
                wr_q <= (lad_in == NIB_MEM_WR);
            end

            // Abort has priority over both start and completion
            if (abort) begin
                req_q <= 1'b0;
            end else if (req_start) begin
                req_q <= 1'b1;
            end else if (accept) begin
                req_q <= 1'b0;
            end

            if (abort || req_start) begin
                done_q <= 1'b0;
            end else if (accept) begin
                done_q <= 1'b1;
            end

            if (accept && !wr_q) begin
                rd_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        drv = '{oe: 1'b0, nib: '0};
        case (state_q)
            S_SYNC: drv = '{oe: 1'b1, nib: sync_code(done_q)};
            S_RLO:  drv = '{oe: 1'b1, nib: rd_q[NIB_W-1:0]};
            S_RHI:  drv = '{oe: 1'b1, nib: rd_q[BYTE_W-1:NIB_W]};
            S_PTAR: drv = '{oe: 1'b1, nib: NIB_TAR};
            default: drv = '{oe: 1'b0, nib: '0};
        endcase
    end

    assign lad_oe  = drv.oe;
    assign lad_out = drv.nib;
    assign mem_req = req_q;
    assign mem_we  = wr_q;
    assign state   = state_q;

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
    import lpcm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_mask,
    input  logic              win_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_done
);

    lpcm_state_e       seq_state;
    logic              addr_shift;
    logic              data_lo;
    logic              data_hi;
    logic              win_hit;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_next;
    logic [BYTE_W-1:0] data_q;

    lpcm_collect #(.ADDR_W(ADDR_W)) u_collect (
        .clk        (clk),
        .rst        (rst),
        .lad_in     (lad_in),
        .addr_shift (addr_shift),
        .data_lo    (data_lo),
        .data_hi    (data_hi),
        .addr_q     (addr_q),
        .addr_next  (addr_next),
        .data_q     (data_q)
    );

    lpcm_window #(.ADDR_W(ADDR_W)) u_window (
        .addr (addr_next),
        .base (win_base),
        .mask (win_mask),
        .en   (win_en),
        .hit  (win_hit)
    );

    lpcm_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .lad_in     (lad_in),
        .win_hit    (win_hit),
        .mem_done   (mem_done),
        .mem_rdata  (mem_rdata),
        .state      (seq_state),
        .addr_shift (addr_shift),
        .data_lo    (data_lo),
        .data_hi    (data_hi),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .lad_out    (lad_out),
        .lad_oe     (lad_oe)
    );

    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;

endmodule

// File: rtl/lpcm_target_chk.sv
module lpcm_target_chk
    import lpcm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_n,
    input logic [3:0]        lad_out,
    input logic              lad_oe,
    input logic              mem_req,
    input logic              mem_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] win_base,
    input logic [ADDR_W-1:0] win_mask,
    input logic              win_en,
    input lpcm_state_e       state
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done && frame_n) |=> mem_req);

    // R11
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_done) |=> !mem_req);

    // R2
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (!lad_oe && !mem_req));

    // R7
    host_phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        is_host_phase(state) |-> !lad_oe);

    // R8
    sync_code_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_SYNC) |-> (lad_oe && ((lad_out == SYNC_READY) || (lad_out == SYNC_LWAIT))));

    // R8
    ready_once_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == S_SYNC) && (lad_out == SYNC_READY)) |=> (state != S_SYNC));

    // R5
    req_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> (win_en && (((mem_addr ^ win_base) & ~win_mask) == '0)));

endmodule

bind lpc_mem_target lpcm_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe),
    .mem_req  (mem_req),
    .mem_done (mem_done),
    .mem_addr (mem_addr),
    .win_base (win_base),
    .win_mask (win_mask),
    .win_en   (win_en),
    .state    (seq_state)
);

// File: tb/lpc_mem_target_test.sv
`timescale 1ns/1ps
module lpc_mem_target_test;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [31:0] win_base = '0;
    logic [31:0] win_mask = '0;
    logic        win_en = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_done = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int delay_cfg = 0;
    int m_cnt = 0;
    logic [7:0] model_mem [256];
    logic [7:0] exp_mem [256];

    always #(HALF) clk = ~clk;

    lpc_mem_target uut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe),
        .win_base(win_base), .win_mask(win_mask), .win_en(win_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    // Local byte memory: completes d negedges after the request is seen
    always @(negedge clk) begin
        if (mem_req) begin
            if (m_cnt == delay_cfg) begin
                mem_done = 1'b1;
                if (mem_we) model_mem[mem_addr[7:0]] = mem_wdata;
                else        mem_rdata = model_mem[mem_addr[7:0]];
            end else begin
                mem_done = 1'b0;
            end
            m_cnt++;
        end else begin
            mem_done = 1'b0;
            m_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic host(input logic fr, input logic [3:0] nib);
        @(negedge clk);
        frame_n = fr;
        lad_in  = nib;
    endtask

    task automatic run_cycle(input bit wr, input logic [31:0] addr, input logic [7:0] wd,
                             input int d, input bit hit, output logic [7:0] rd);
        bit quiet = 1'b1;
        bit ok = 1'b1;
        int waits = 0;
        int exp_w;
        logic [3:0] lo, hi;
        rd = '0;
        exp_w = (d > 1) ? d - 1 : 0;
        delay_cfg = d;
        host(1'b0, 4'b0000);
        host(1'b1, wr ? 4'b0110 : 4'b0100);
        quiet &= !lad_oe;
        for (int i = 7; i >= 0; i--) begin
            host(1'b1, addr[i*4 +: 4]);
            quiet &= !lad_oe;
        end
        if (wr) begin
            host(1'b1, wd[3:0]); quiet &= !lad_oe;
            host(1'b1, wd[7:4]); quiet &= !lad_oe;
        end
        host(1'b1, 4'hF);
        chk(quiet && !lad_oe, "R7", "target quiet in host phase", {31'd0, lad_oe}, 0);
        chk(mem_req == hit, "R5", "claim decision", {31'd0, mem_req}, {31'd0, hit});
        if (!hit) begin
            for (int i = 0; i < 6; i++) begin
                host(1'b1, 4'hF);
                quiet &= !lad_oe && !mem_req;
            end
            chk(quiet, "R5", "missed cycle stays off bus", {31'd0, quiet}, 1);
            return;
        end
        chk(mem_addr == addr, "R4", "address assembly", mem_addr, addr);
        chk(mem_we == wr, "R11", "write flag", {31'd0, mem_we}, {31'd0, wr});
        if (wr) chk(mem_wdata == wd, "R6", "write byte order", {24'd0, mem_wdata}, {24'd0, wd});
        host(1'b1, 4'bzzzz);
        chk(!lad_oe, "R7", "float turnaround clock", {31'd0, lad_oe}, 0);
        forever begin
            @(negedge clk);
            if (!lad_oe) begin ok = 1'b0; break; end
            if (lad_out == 4'b0110) begin
                waits++;
                if (waits > 60) begin ok = 1'b0; break; end
            end else if (lad_out == 4'b0000) begin
                break;
            end else begin
                ok = 1'b0; break;
            end
        end
        chk(ok, "R8", "sync nibble legal", {28'd0, lad_out}, 0);
        chk(waits == exp_w, "R8", "long-wait count", waits, exp_w);
        if (!wr) begin
            @(negedge clk); lo = lad_out; ok = lad_oe;
            @(negedge clk); hi = lad_out; ok &= lad_oe;
            rd = {hi, lo};
            chk(ok, "R9", "data nibbles driven", {31'd0, ok}, 1);
        end
        @(negedge clk);
        chk(lad_oe && lad_out == 4'hF, wr ? "R10" : "R9", "closing 1111",
            {27'd0, lad_oe, lad_out}, 32'h1F);
        @(negedge clk);
        chk(!lad_oe, wr ? "R10" : "R9", "bus released", {31'd0, lad_oe}, 0);
    endtask

    initial begin
        #(200000 * 5.0);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  rd;
        logic [31:0] a;
        logic [7:0]  wd;
        bit ok;
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = 8'(i) ^ 8'hC3;
            exp_mem[i]   = 8'(i) ^ 8'hC3;
        end
        win_base = 32'h1234_56A7;
        win_mask = 32'h0000_00FF;
        win_en   = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        chk(!lad_oe && !mem_req, "R1", "reset outputs", {30'd0, lad_oe, mem_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!lad_oe && !mem_req, "R1", "first clock after reset", {30'd0, lad_oe, mem_req}, 0);

        // Latency sweep over writes then reads (R4 R6 R8 R9 R10 R11)
        for (int d = 0; d < 6; d++) begin
            for (int k = 0; k < 4; k++) begin
                a  = 32'h1234_5600 | ((k * 61 + d * 7) & 32'hFF);
                wd = 8'((a[7:0] * 37 + d * 11)) ^ 8'h5A;
                run_cycle(1'b1, a, wd, d, 1'b1, rd);
                exp_mem[a[7:0]] = wd;
                run_cycle(1'b0, a, 8'h00, d, 1'b1, rd);
                chk(rd == exp_mem[a[7:0]], "R9", "read-back byte", {24'd0, rd}, {24'd0, exp_mem[a[7:0]]});
            end
        end

        // Window misses leave memory untouched (R5)
        run_cycle(1'b1, 32'h1235_5610, 8'hEE, 0, 1'b0, rd);
        run_cycle(1'b1, 32'h9234_5610, 8'hEE, 0, 1'b0, rd);
        run_cycle(1'b0, 32'h1234_5610, 8'h00, 1, 1'b1, rd);
        chk(rd == exp_mem[8'h10], "R5", "memory after misses", {24'd0, rd}, {24'd0, exp_mem[8'h10]});

        // Decode disabled (R5)
        win_en = 1'b0;
        run_cycle(1'b0, 32'h1234_5620, 8'h00, 0, 1'b0, rd);
        win_en = 1'b1;

        // Narrow window (R5)
        win_base = 32'h1234_5670;
        win_mask = 32'h0000_000F;
        run_cycle(1'b0, 32'h1234_567F, 8'h00, 2, 1'b1, rd);
        chk(rd == exp_mem[8'h7F], "R5", "narrow window hit data", {24'd0, rd}, {24'd0, exp_mem[8'h7F]});
        run_cycle(1'b0, 32'h1234_5680, 8'h00, 0, 1'b0, rd);
        win_base = 32'h1234_5600;
        win_mask = 32'h0000_00FF;

        // Unsupported cycle type (R3)
        host(1'b0, 4'b0000);
        host(1'b1, 4'b0010);
        ok = 1'b1;
        for (int i = 0; i < 14; i++) begin
            host(1'b1, 4'(i));
            ok &= !lad_oe && !mem_req;
        end
        chk(ok, "R3", "other cycle type ignored", {31'd0, ok}, 1);

        // Frame held low across a non-start nibble, then start (R2)
        host(1'b0, 4'h5);
        run_cycle(1'b0, 32'h1234_5633, 8'h00, 0, 1'b1, rd);
        chk(rd == exp_mem[8'h33], "R2", "restart after frame held", {24'd0, rd}, {24'd0, exp_mem[8'h33]});

        // Abort during long waits (R2)
        delay_cfg = 12;
        host(1'b0, 4'b0000);
        host(1'b1, 4'b0100);
        for (int i = 7; i >= 0; i--) host(1'b1, a[i*4 +: 4]);
        host(1'b1, 4'hF);
        host(1'b1, 4'hF);
        @(negedge clk);
        chk(lad_oe && lad_out == 4'b0110, "R8", "long wait before abort", {27'd0, lad_oe, lad_out}, 32'h16);
        frame_n = 1'b0;
        lad_in  = 4'hF;
        host(1'b1, 4'hF);
        chk(!lad_oe && !mem_req, "R2", "abort during waits", {30'd0, lad_oe, mem_req}, 0);
        repeat (3) host(1'b1, 4'hF);

        // Abort sampled on the same edge as completion (R2)
        delay_cfg = 1;
        host(1'b0, 4'b0000);
        host(1'b1, 4'b0100);
        for (int i = 7; i >= 0; i--) host(1'b1, a[i*4 +: 4]);
        host(1'b1, 4'hF);
        host(1'b0, 4'hF);
        host(1'b1, 4'hF);
        chk(!lad_oe && !mem_req, "R2", "abort wins over completion", {30'd0, lad_oe, mem_req}, 0);
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            host(1'b1, 4'hF);
            ok &= !lad_oe;
        end
        chk(ok, "R2", "no ready after abort", {31'd0, ok}, 1);

        // Normal cycle after aborts (R2)
        run_cycle(1'b0, 32'h1234_5644, 8'h00, 3, 1'b1, rd);
        chk(rd == exp_mem[8'h44], "R2", "recovery read", {24'd0, rd}, {24'd0, exp_mem[8'h44]});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule